// File: doc/BRIEF.md
# Configurable Processor Register Cell

This block is one address-decoded register for the internal register bus of a small processor. A register map is built by placing many copies side by side on a shared address, write strobe, read strobe and write data bus. Each copy drives zero on its read data output unless it is the one being read, so the read data of all copies can simply be ORed together onto one return bus.

On the core side every cell has a hardware input, a hardware enable and a hardware output. Two parameters fix its personality. The first chooses whether bus writes are latched and driven onto the hardware output, or ignored. The second chooses what a bus read returns: the live hardware input, the latched write value, a sticky record of hardware events that software clears by writing ones, or a snapshot taken only while the hardware enable is high. A live-bit mask parameter limits which bits exist at all.

A read-hit output pulses while the cell is being read. When it is fed into the enable of a second cell in snapshot mode, the pair gives a consistent wide read: reading the low half freezes the high half, which software reads next.

Top module: `preg_cell`

## Requirements
- R1: The cell responds only when the bus address equals the ADDR parameter and the read strobe is high. At any other time its read data is all zeros, and a write to another address changes nothing in the cell.
- R2: With output mode OUT_LATCH, a write strobe at ADDR stores the masked write data at the next rising clock edge and drives it on the hardware output until the next such write. With OUT_NONE the hardware output is always zero.
- R3: In read mode RD_THRU a read returns the current masked hardware input, combinationally; bus writes do not change what is read.
- R4: In read mode RD_OUT a read returns the value held by the write latch, giving ordinary read/write behaviour.
- R5: In read mode RD_STICKY every stored bit whose hardware input bit is 1 at a rising edge becomes 1 and stays 1 until cleared.
- R6: In read mode RD_STICKY a write at ADDR clears exactly the stored bits whose write data bit is 1 and leaves the others unchanged.
- R7: In read mode RD_STICKY, when a hardware set and a bus clear hit the same bit in the same cycle, the bit ends up set.
- R8: In read mode RD_SNAP the hardware input is copied into a holding register at each rising edge where the hardware enable is high, and held otherwise; reads return the holding register, and bus writes do not alter it.
- R9: The read-hit output is high exactly while the read strobe is high and the address equals ADDR.
- R10: Bits that are 0 in LIVE_MASK always read as zero, are never stored and are always zero on the hardware output.
- R11: A synchronous active-high reset clears the write latch, the sticky bits and the holding register to zero.
- R12: With a low cell's read-hit driving a high cell's hardware enable, the high cell read in a later cycle returns the high input value present during the low read, even if the high input changed in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, zero when the cell is not read |
| hw_in | input | DATA_W | Value from core logic |
| hw_en | input | 1 | Capture enable for snapshot mode |
| hw_out | output | DATA_W | Latched write value toward core logic |
| rd_hit | output | 1 | High while this cell is being read |

## Verification
The collision worth provoking is a hardware event and a software clear landing on the same sticky bit in one cycle: the bench raises the hardware input bit and issues a write with that bit set in the same cycle, then reads the cell and expects the bit still set, while a later lone clear is expected to remove it. A second overlap is the low-half read and the high-half capture happening on the same edge; the bench changes the high input right after that edge and expects the earlier value when the high half is read.

// File: rtl/preg_pkg.sv
package preg_pkg;

    // What a bus write does to the hardware output
    typedef enum logic {
        OUT_NONE  = 1'b0,
        OUT_LATCH = 1'b1
    } out_mode_e;

    // What a bus read returns
    typedef enum logic [1:0] {
        RD_THRU   = 2'd0,
        RD_OUT    = 2'd1,
        RD_STICKY = 2'd2,
        RD_SNAP   = 2'd3
    } rd_mode_e;

    // Decoded bus strobes for this cell
    typedef struct packed {
        logic rd_hit;
        logic wr_hit;
    } bus_hit_t;

endpackage

// File: rtl/preg_decode.sv
module preg_decode
    import preg_pkg::*;
#(
    parameter int                ADDR_W = 4,
    parameter logic [ADDR_W-1:0] ADDR   = '0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output bus_hit_t          hit
);

    logic match;

    always_comb begin
        match      = (bus_addr == ADDR);
        hit.rd_hit = match & bus_rd;
        hit.wr_hit = match & bus_wr;
    end

endmodule

// File: rtl/preg_wlatch.sv
module preg_wlatch
    import preg_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter out_mode_e         OUT_MODE  = OUT_LATCH,
    parameter logic [DATA_W-1:0] LIVE_MASK = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    generate
        if (OUT_MODE == OUT_LATCH) begin : g_latch
            logic [DATA_W-1:0] store;
            always_ff @(posedge clk) begin
                if (rst) begin
                    store <= '0;
                end else if (wr_hit) begin
                    store <= wdata & LIVE_MASK;
                end
            end
            assign q = store;
        end else begin : g_none
            logic unused_wl;
            assign unused_wl = ^{clk, rst, wr_hit, wdata};
            assign q = '0;
        end
    endgenerate

endmodule

// File: rtl/preg_capture.sv
module preg_capture
    import preg_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter rd_mode_e          RD_MODE   = RD_THRU,
    parameter logic [DATA_W-1:0] LIVE_MASK = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] hw_in,
    input  logic              hw_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_bits,
    output logic [DATA_W-1:0] q
);

    generate
        if (RD_MODE == RD_STICKY) begin : g_sticky
            logic [DATA_W-1:0] flags;
            logic [DATA_W-1:0] clr_vec;
            logic [DATA_W-1:0] nxt;
            logic              unused_cp;
            assign unused_cp = hw_en;
            always_comb begin
                clr_vec = clr_en ? clr_bits : '0;
                // set is ORed after the clear so a same-cycle event survives
                nxt     = ((flags & ~clr_vec) | hw_in) & LIVE_MASK;
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    flags <= '0;
                end else begin
                    flags <= nxt;
                end
            end
            assign q = flags;
        end else if (RD_MODE == RD_SNAP) begin : g_snap
            logic [DATA_W-1:0] hold;
            logic              unused_cp;
            assign unused_cp = ^{clr_en, clr_bits};
            always_ff @(posedge clk) begin
                if (rst) begin
                    hold <= '0;
                end else if (hw_en) begin
                    hold <= hw_in & LIVE_MASK;
                end
            end
            assign q = hold;
        end else begin : g_none
            logic unused_cp;
            assign unused_cp = ^{clk, rst, hw_in, hw_en, clr_en, clr_bits};
            assign q = '0;
        end
    endgenerate

endmodule

// File: rtl/preg_cell.sv
module preg_cell
    import preg_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter int                DATA_W    = 16,
    parameter logic [ADDR_W-1:0] ADDR      = '0,
    parameter out_mode_e         OUT_MODE  = OUT_LATCH,
    parameter rd_mode_e          RD_MODE   = RD_OUT,
    parameter logic [DATA_W-1:0] LIVE_MASK = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] hw_in,
    input  logic              hw_en,
    output logic [DATA_W-1:0] hw_out,
    output logic              rd_hit
);

    bus_hit_t          hit;
    logic [DATA_W-1:0] latch_q;
    logic [DATA_W-1:0] cap_q;
    logic [DATA_W-1:0] rd_val;

    preg_decode #(
        .ADDR_W (ADDR_W),
        .ADDR   (ADDR)
    ) i_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .hit      (hit)
    );

    preg_wlatch #(
        .DATA_W    (DATA_W),
        .OUT_MODE  (OUT_MODE),
        .LIVE_MASK (LIVE_MASK)
    ) i_wlatch (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (hit.wr_hit),
        .wdata  (bus_wdata),
        .q      (latch_q)
    );

    preg_capture #(
        .DATA_W    (DATA_W),
        .RD_MODE   (RD_MODE),
        .LIVE_MASK (LIVE_MASK)
    ) i_capture (
        .clk      (clk),
        .rst      (rst),
        .hw_in    (hw_in),
        .hw_en    (hw_en),
        .clr_en   (hit.wr_hit),
        .clr_bits (bus_wdata),
        .q        (cap_q)
    );

    always_comb begin
        unique case (RD_MODE)
            RD_THRU:   rd_val = hw_in;
            RD_OUT:    rd_val = latch_q;
            default:   rd_val = cap_q;
        endcase
    end

    assign bus_rdata = hit.rd_hit ? (rd_val & LIVE_MASK) : '0;
    assign hw_out    = latch_q;
    assign rd_hit    = hit.rd_hit;

endmodule

// File: rtl/preg_cell_chk.sv
module preg_cell_chk
    import preg_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter int                DATA_W    = 16,
    parameter logic [ADDR_W-1:0] ADDR      = '0,
    parameter out_mode_e         OUT_MODE  = OUT_LATCH,
    parameter rd_mode_e          RD_MODE   = RD_OUT,
    parameter logic [DATA_W-1:0] LIVE_MASK = '1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] hw_in,
    input logic              hw_en,
    input logic [DATA_W-1:0] hw_out,
    input logic              rd_hit
);

    logic wr_sel;
    assign wr_sel = bus_wr && (bus_addr == ADDR);

    AST_RD_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_addr == ADDR) |-> bus_rdata == '0); // R1

    AST_HIT_NEEDS_RD: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> (bus_rd && bus_addr == ADDR)); // R9

    AST_RD_MASKED: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & ~LIVE_MASK) == '0); // R10

    AST_OUT_MASKED: assert property (@(posedge clk) disable iff (rst)
        (hw_out & ~LIVE_MASK) == '0); // R10

    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (rst)
        (OUT_MODE == OUT_LATCH && wr_sel) |=> hw_out == ($past(bus_wdata) & LIVE_MASK)); // R2

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_sel && !$past(rst)) |=> $stable(hw_out)); // R2

    AST_NONE_ZERO: assert property (@(posedge clk) disable iff (rst)
        OUT_MODE == OUT_NONE |-> hw_out == '0); // R2

    AST_THRU_LIVE: assert property (@(posedge clk) disable iff (rst)
        (RD_MODE == RD_THRU && rd_hit) |-> bus_rdata == (hw_in & LIVE_MASK)); // R3

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
        (RD_MODE == RD_STICKY && rd_hit && !$past(rst))
        |-> (bus_rdata & $past(hw_in) & LIVE_MASK) == ($past(hw_in) & LIVE_MASK)); // R5

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (RD_MODE == RD_SNAP && rd_hit && $past(rd_hit) && !$past(hw_en) && !$past(rst))
        |-> $stable(bus_rdata)); // R8

    AST_RESET_OUT: assert property (@(posedge clk)
        rst |=> hw_out == '0); // R11

endmodule

bind preg_cell preg_cell_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ADDR      (ADDR),
    .OUT_MODE  (OUT_MODE),
    .RD_MODE   (RD_MODE),
    .LIVE_MASK (LIVE_MASK)
) i_preg_cell_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hw_in     (hw_in),
    .hw_en     (hw_en),
    .hw_out    (hw_out),
    .rd_hit    (rd_hit)
);

// File: tb/test_preg_cell.sv
`timescale 1ns/1ps
module test_preg_cell;
    import preg_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] th_in = '0, stk_in = '0, lo_in = '0, hi_in = '0;

    logic [15:0] rd_out, rd_thru, rd_stk, rd_lo, rd_hi, bus_rdata;
    logic [15:0] out_hw, thru_hw, stk_hw, lo_hw, hi_hw;
    logic        out_hit, thru_hit, stk_hit, lo_hit, hi_hit;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    // read/write cell at address 3, 8 live bits
    preg_cell #(.ADDR(4'd3), .OUT_MODE(OUT_LATCH), .RD_MODE(RD_OUT), .LIVE_MASK(16'h00FF)) i_preg_cell (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rd_out), .hw_in(16'h0), .hw_en(1'b0),
        .hw_out(out_hw), .rd_hit(out_hit));

    // pass-through cell at address 1, 3 live bits, no latch
    preg_cell #(.ADDR(4'd1), .OUT_MODE(OUT_NONE), .RD_MODE(RD_THRU), .LIVE_MASK(16'h0007)) i_preg_cell_thru (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rd_thru), .hw_in(th_in), .hw_en(1'b0),
        .hw_out(thru_hw), .rd_hit(thru_hit));

    // sticky cell at address 5, 12 live bits
    preg_cell #(.ADDR(4'd5), .OUT_MODE(OUT_NONE), .RD_MODE(RD_STICKY), .LIVE_MASK(16'h0FFF)) i_preg_cell_stk (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rd_stk), .hw_in(stk_in), .hw_en(1'b0),
        .hw_out(stk_hw), .rd_hit(stk_hit));

    // wide pair: low half at 8, high half at 9 frozen by the low read
    preg_cell #(.ADDR(4'd8), .OUT_MODE(OUT_LATCH), .RD_MODE(RD_THRU)) i_preg_cell_lo (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rd_lo), .hw_in(lo_in), .hw_en(1'b0),
        .hw_out(lo_hw), .rd_hit(lo_hit));

    preg_cell #(.ADDR(4'd9), .OUT_MODE(OUT_LATCH), .RD_MODE(RD_SNAP)) i_preg_cell_hi (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rd_hi), .hw_in(hi_in), .hw_en(lo_hit),
        .hw_out(hi_hw), .rd_hit(hi_hit));

    assign bus_rdata = rd_out | rd_thru | rd_stk | rd_lo | rd_hi;

    // {addr[4], wr, rd, wdata[16], expected rdata[16], expected out_hw[16]}
    localparam int NV = 9;
    localparam logic [53:0] VEC [NV] = '{
        {4'd3, 1'b1, 1'b0, 16'h00A5, 16'h0000, 16'h0000},
        {4'd3, 1'b0, 1'b1, 16'h0000, 16'h00A5, 16'h00A5},
        {4'd3, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 16'h00A5},
        {4'd3, 1'b0, 1'b1, 16'h0000, 16'h00FF, 16'h00FF},
        {4'd2, 1'b1, 1'b0, 16'h1234, 16'h0000, 16'h00FF},
        {4'd3, 1'b0, 1'b1, 16'h0000, 16'h00FF, 16'h00FF},
        {4'd2, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h00FF},
        {4'd3, 1'b1, 1'b1, 16'h003C, 16'h00FF, 16'h00FF},
        {4'd3, 1'b0, 1'b1, 16'h0000, 16'h003C, 16'h003C}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // apply one bus cycle after the falling edge and let it settle
    task automatic drive(input logic [3:0] a, input logic w, input logic r, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wr    = w;
        bus_rd    = r;
        bus_wdata = d;
        #1;
    endtask

    task automatic idle();
        drive(4'd0, 1'b0, 1'b0, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state, R11
        drive(4'd3, 1'b0, 1'b1, 16'h0);
        chk("R11 latch read after reset", bus_rdata, 16'h0);
        chk("R11 hw_out after reset", out_hw, 16'h0);
        drive(4'd5, 1'b0, 1'b1, 16'h0);
        chk("R11 sticky after reset", bus_rdata, 16'h0);
        drive(4'd9, 1'b0, 1'b1, 16'h0);
        chk("R11 snapshot after reset", bus_rdata, 16'h0);

        // vector table: R1 R2 R4 R10 on the read/write cell
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][53:50], VEC[i][49], VEC[i][48], VEC[i][47:32]);
            chk($sformatf("R4 vec %0d rdata", i), bus_rdata, VEC[i][31:16]);
            chk($sformatf("R2 vec %0d hw_out", i), out_hw, VEC[i][15:0]);
        end

        // pass-through: R3 R10, OUT_NONE: R2
        th_in = 16'h0005;
        drive(4'd1, 1'b0, 1'b1, 16'h0);
        chk("R3 thru read", bus_rdata, 16'h0005);
        th_in = 16'hFFFF;
        #1;
        chk("R10 thru masked", bus_rdata, 16'h0007);
        drive(4'd1, 1'b1, 1'b0, 16'h0000);
        th_in = 16'h0002;
        drive(4'd1, 1'b0, 1'b1, 16'h0);
        chk("R3 thru write ignored", bus_rdata, 16'h0002);
        chk("R2 none mode hw_out", thru_hw, 16'h0);

        // read hit indication: R9
        drive(4'd8, 1'b0, 1'b1, 16'h0);
        chk("R9 hit on read", {15'h0, lo_hit}, 16'h1);
        drive(4'd9, 1'b0, 1'b1, 16'h0);
        chk("R9 no hit other addr", {15'h0, lo_hit}, 16'h0);
        drive(4'd8, 1'b1, 1'b0, 16'h0);
        chk("R9 no hit on write", {15'h0, lo_hit}, 16'h0);
        chk("R1 no read data on write", bus_rdata, 16'h0);

        // sticky capture: R5 R6 R7 R10
        idle();
        stk_in = 16'h0F05;
        idle();
        stk_in = 16'h0000;
        drive(4'd5, 1'b0, 1'b1, 16'h0);
        chk("R5 sticky set", bus_rdata, 16'h0F05);
        idle();
        chk("R5 sticky holds", rd_stk, 16'h0000);
        drive(4'd5, 1'b0, 1'b1, 16'h0);
        chk("R5 sticky still set", bus_rdata, 16'h0F05);
        stk_in = 16'hF000;
        idle();
        stk_in = 16'h0000;
        drive(4'd5, 1'b0, 1'b1, 16'h0);
        chk("R10 sticky dead bits", bus_rdata, 16'h0F05);
        drive(4'd5, 1'b1, 1'b0, 16'h0005);
        drive(4'd5, 1'b0, 1'b1, 16'h0);
        chk("R6 clear selected bits", bus_rdata, 16'h0F00);
        drive(4'd5, 1'b1, 1'b0, 16'h0100);
        stk_in = 16'h0100;
        idle();
        stk_in = 16'h0000;
        drive(4'd5, 1'b0, 1'b1, 16'h0);
        chk("R7 set wins over clear", bus_rdata, 16'h0F00);
        drive(4'd5, 1'b1, 1'b0, 16'h0F00);
        drive(4'd5, 1'b0, 1'b1, 16'h0);
        chk("R6 clear all", bus_rdata, 16'h0000);

        // wide pair: R12 R8
        lo_in = 16'h1111;
        hi_in = 16'hAAAA;
        drive(4'd8, 1'b0, 1'b1, 16'h0);
        chk("R12 low half", bus_rdata, 16'h1111);
        @(posedge clk);
        #1;
        hi_in = 16'hBBBB;
        drive(4'd9, 1'b0, 1'b1, 16'h0);
        chk("R12 high half frozen", bus_rdata, 16'hAAAA);
        hi_in = 16'hCCCC;
        idle();
        idle();
        drive(4'd9, 1'b0, 1'b1, 16'h0);
        chk("R8 hold without enable", bus_rdata, 16'hAAAA);
        drive(4'd9, 1'b1, 1'b0, 16'h5A5A);
        drive(4'd9, 1'b0, 1'b1, 16'h0);
        chk("R8 write leaves snapshot", bus_rdata, 16'hAAAA);
        chk("R2 high latch written", hi_hw, 16'h5A5A);
        drive(4'd8, 1'b0, 1'b1, 16'h0);
        drive(4'd9, 1'b0, 1'b1, 16'h0);
        chk("R8 recapture", bus_rdata, 16'hCCCC);

        // mid-run reset: R11
        stk_in = 16'h0001;
        idle();
        stk_in = 16'h0000;
        rst = 1'b1;
        idle();
        rst = 1'b0;
        drive(4'd3, 1'b0, 1'b1, 16'h0);
        chk("R11 latch cleared", bus_rdata, 16'h0);
        chk("R11 hw_out cleared", out_hw, 16'h0);
        drive(4'd5, 1'b0, 1'b1, 16'h0);
        chk("R11 sticky cleared", bus_rdata, 16'h0);
        drive(4'd9, 1'b0, 1'b1, 16'h0);
        chk("R11 snapshot cleared", bus_rdata, 16'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule